// File: doc/BRIEF.md
# Signaling Change Address FIFO

This block sits beside the control memory of a time-division switching highway. Each frame it receives, slot by slot, the current value of two kinds of per-slot signaling: command/indicate (C/I) channels and signaling (SIG) channels. It keeps a shadow copy of the last value reported for every slot. When a value moves away from its shadow copy, the block writes the slot's control-memory address into a small first-in first-out queue. A C/I change is reported as soon as it is seen. A SIG change is reported only after the new value has held for two consecutive updates of that slot.

A host processor drains the queue one byte at a time. The top bit of each byte is a valid flag. The low seven bits are the address: the slot number shifted left by one, with the channel type in bit 0. A C/I change therefore gives an even address and a SIG change gives an odd one. Because the flag sits in the top bit, the host can copy the byte unchanged into its memory address register and fetch the new value.

If the queue is already full when a change occurs, the event is lost and a sticky overflow flag is raised. The host clears the flag by reading it.

Top module: `slotChangeQueue`

## Requirements
- R1: After reset the queue is empty, `rdData` reads 0x00 and `ovfStat` is 0. All shadow and candidate values reset to 0.
- R2: A C/I update (`updIsSig`=0) whose value differs from the slot's shadow queues the byte {1, slot[5:0], 0}, an even address. The shadow then takes the new value.
- R3: A C/I update that equals the slot's shadow queues nothing.
- R4: A SIG update (`updIsSig`=1) that differs from the shadow queues nothing the first time it is seen. The second consecutive update of that slot with the same value queues {1, slot[5:0], 1}, an odd address, and the shadow takes the value.
- R5: A SIG value seen on only one update queues nothing. This holds whether the slot then returns to its shadow value or moves to a third value, and the third value starts a fresh two-update count.
- R6: `rdData` bit 7 is 1 with bits 6..0 holding the oldest queued address, or the whole byte is 0x00 when the queue is empty. Asserting `rdEn` while the queue is empty has no effect on the queue.
- R7: Entries are read out in the order their changes occurred. Asserting `rdEn` removes the presented entry at the next clock edge.
- R8: The queue holds 9 entries. A change that occurs while the queue is full, with no read in the same cycle, is dropped and sets `ovfStat`. The shadow still takes the new value, so repeating that value queues nothing.
- R9: `ovfStat` stays set until a cycle with `ovfRd` asserted, after which it reads 0. A new drop in the same cycle as `ovfRd` keeps it set.
- R10: When the queue is full, a change and a read in the same cycle are both accepted. Occupancy stays at 9 and nothing is flagged.
- R11: A queued entry appears on `rdData` at the first clock edge after the update is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| updValid | input | 1 | A slot value is presented this cycle |
| updSlot | input | 6 | Time-slot index of the update |
| updIsSig | input | 1 | 0 = C/I channel, 1 = SIG channel |
| updValue | input | 4 | Current value of the channel |
| rdEn | input | 1 | Host read; pops the presented entry |
| rdData | output | 8 | {valid, address[6:0]} of the oldest entry, 0x00 when empty |
| ovfRd | input | 1 | Host reads and clears the overflow flag |
| ovfStat | output | 1 | Sticky flag: a change was dropped on a full queue |

## Verification
The bench attacks three things: the SIG debounce, the full-queue boundary, and empty reads. For the debounce it sends single-frame glitches and sequences that restart the count with a third value. A design that compared only against the shadow would queue the glitch, and one that did not restart the count would report too early. At the full boundary it overflows the queue and then repeats the dropped value. A design that skipped the shadow update on a drop would queue a stale entry later. A design that gated the push on "not full" alone would lose the event from a simultaneous read and write. Finally, it reads an empty queue and checks both the cleared flag and that no phantom entry appears.

// File: rtl/scq_pkg.sv
package scq_pkg;

  // Comparison results the datapath reports for the update on its inputs.
  typedef struct packed {
    logic ciDiff;     // value differs from C/I shadow
    logic sigDiff;    // value differs from SIG shadow
    logic candSeen;   // a SIG candidate is pending for this slot
    logic candMatch;  // pending candidate equals the value
  } cmp_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic push;
    logic pop;
    logic ciWr;
    logic sigWr;
    logic candSet;
    logic candClr;
  } strobe_t;

endpackage

// File: rtl/scqCtrl.sv
module scqCtrl
  import scq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    updValid,
  input  logic    updIsSig,
  input  cmp_t    cmp,
  input  logic    rdEn,
  input  logic    ovfRd,
  input  logic    empty,
  input  logic    full,
  output strobe_t strb,
  output logic    ovfStat
);

  logic sigStable;
  logic ciEvt;
  logic sigEvt;
  logic evt;
  logic drop;
  logic ovfQ;

  // A SIG value is reported once it has been seen on two consecutive updates.
  assign sigStable = cmp.sigDiff && cmp.candSeen && cmp.candMatch;
  assign ciEvt     = updValid && !updIsSig && cmp.ciDiff;
  assign sigEvt    = updValid && updIsSig && sigStable;
  assign evt       = ciEvt || sigEvt;

  always_comb begin
    strb         = '0;
    strb.pop     = rdEn && !empty;
    strb.push    = evt && (!full || strb.pop);
    strb.ciWr    = ciEvt;
    strb.sigWr   = sigEvt;
    strb.candSet = updValid && updIsSig && cmp.sigDiff && !sigStable;
    strb.candClr = updValid && updIsSig && (!cmp.sigDiff || sigStable);
  end

  assign drop = evt && full && !strb.pop;

  always_ff @(posedge clk) begin
    if (!rstN)        ovfQ <= 1'b0;
    else if (drop)    ovfQ <= 1'b1;
    else if (ovfRd)   ovfQ <= 1'b0;
  end

  assign ovfStat = ovfQ;

  p_ovf_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    (evt && full && !rdEn) |=> ovfStat);

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ovfStat && !ovfRd) |=> ovfStat);

  p_ovf_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ovfRd && !(evt && full && !rdEn)) |=> !ovfStat);

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> (!full || strb.pop));

endmodule

// File: rtl/scqDatapath.sv
module scqDatapath
  import scq_pkg::*;
#(
  parameter int SLOTS = 64,
  parameter int DEPTH = 9,
  parameter int VAL_W = 4,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int ADDR_W = SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SLOT_W-1:0] updSlot,
  input  logic              updIsSig,
  input  logic [VAL_W-1:0]  updValue,
  input  strobe_t           strb,
  output cmp_t              cmp,
  output logic              empty,
  output logic              full,
  output logic [ADDR_W:0]   rdData
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [VAL_W-1:0]  ciShadow  [SLOTS];
  logic [VAL_W-1:0]  sigShadow [SLOTS];
  logic [VAL_W-1:0]  sigCand   [SLOTS];
  logic [SLOTS-1:0]  candSeenQ;

  logic [ADDR_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [CNT_W-1:0]  count;

  // Shadow comparison for the slot on the inputs.
  always_comb begin
    cmp           = '0;
    cmp.ciDiff    = updValue != ciShadow[updSlot];
    cmp.sigDiff   = updValue != sigShadow[updSlot];
    cmp.candSeen  = candSeenQ[updSlot];
    cmp.candMatch = sigCand[updSlot] == updValue;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SLOTS; i++) begin
        ciShadow[i]  <= '0;
        sigShadow[i] <= '0;
        sigCand[i]   <= '0;
      end
      candSeenQ <= '0;
    end else begin
      if (strb.ciWr)  ciShadow[updSlot]  <= updValue;
      if (strb.sigWr) sigShadow[updSlot] <= updValue;
      if (strb.candSet) begin
        sigCand[updSlot]   <= updValue;
        candSeenQ[updSlot] <= 1'b1;
      end else if (strb.candClr) begin
        candSeenQ[updSlot] <= 1'b0;
      end
    end
  end

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Entry: slot number above the channel-type bit (0 = C/I, 1 = SIG).
  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr] <= {updSlot, updIsSig};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.push) wrPtr <= nextPtr(wrPtr);
      if (strb.pop)  rdPtr <= nextPtr(rdPtr);
      case ({strb.push, strb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign rdData = empty ? '0 : {1'b1, mem[rdPtr]};

  p_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  p_grow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && !strb.pop) |=> (count == CNT_W'($past(count) + 1'b1)));

  p_swap_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && strb.pop) |=> $stable(count));

  p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> !empty);

  p_visible_r11: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |=> rdData[ADDR_W]);

endmodule

// File: rtl/slotChangeQueue.sv
module slotChangeQueue
  import scq_pkg::*;
#(
  parameter int SLOTS = 64,
  parameter int DEPTH = 9,
  parameter int VAL_W = 4,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int ADDR_W = SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              updValid,
  input  logic [SLOT_W-1:0] updSlot,
  input  logic              updIsSig,
  input  logic [VAL_W-1:0]  updValue,
  input  logic              rdEn,
  output logic [ADDR_W:0]   rdData,
  input  logic              ovfRd,
  output logic              ovfStat
);

  cmp_t    cmp;
  strobe_t strb;
  logic    empty;
  logic    full;

  scqCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .updValid (updValid),
    .updIsSig (updIsSig),
    .cmp      (cmp),
    .rdEn     (rdEn),
    .ovfRd    (ovfRd),
    .empty    (empty),
    .full     (full),
    .strb     (strb),
    .ovfStat  (ovfStat)
  );

  scqDatapath #(
    .SLOTS (SLOTS),
    .DEPTH (DEPTH),
    .VAL_W (VAL_W)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .updSlot  (updSlot),
    .updIsSig (updIsSig),
    .updValue (updValue),
    .strb     (strb),
    .cmp      (cmp),
    .empty    (empty),
    .full     (full),
    .rdData   (rdData)
  );

endmodule

// File: tb/sim_slotChangeQueue.sv
module sim_slotChangeQueue;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       updValid = 1'b0;
  logic [5:0] updSlot = '0;
  logic       updIsSig = 1'b0;
  logic [3:0] updValue = '0;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;
  logic       ovfRd = 1'b0;
  logic       ovfStat;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  logic [7:0] expQ[$];
  logic [3:0] ciM   [64];
  logic [3:0] sigM  [64];
  logic [3:0] candV [64];
  bit         candS [64];
  bit         expOvf = 1'b0;

  always #10 clk = ~clk;

  slotChangeQueue u0 (
    .clk(clk), .rstN(rstN), .updValid(updValid), .updSlot(updSlot),
    .updIsSig(updIsSig), .updValue(updValue), .rdEn(rdEn), .rdData(rdData),
    .ovfRd(ovfRd), .ovfStat(ovfStat)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic enq(logic [7:0] b);
    if (expQ.size() < 9) expQ.push_back(b);
    else expOvf = 1'b1;
  endtask

  // Reference model derived from R2..R5 and R8.
  task automatic modelUpd(int s, bit isSig, logic [3:0] v);
    if (!isSig) begin
      if (v != ciM[s]) begin
        ciM[s] = v;
        enq({1'b1, 6'(s), 1'b0});
      end
    end else if (v == sigM[s]) begin
      candS[s] = 1'b0;
    end else if (candS[s] && candV[s] == v) begin
      sigM[s]  = v;
      candS[s] = 1'b0;
      enq({1'b1, 6'(s), 1'b1});
    end else begin
      candV[s] = v;
      candS[s] = 1'b1;
    end
  endtask

  // Driver: called and returns at a falling edge.
  task automatic upd(int s, bit isSig, logic [3:0] v);
    updValid = 1'b1;
    updSlot  = 6'(s);
    updIsSig = isSig;
    updValue = v;
    modelUpd(s, isSig, v);
    @(negedge clk);
    updValid = 1'b0;
  endtask

  // Monitor: compares the presented byte with the scoreboard, then pops.
  task automatic readChk(string req);
    logic [7:0] e;
    e = (expQ.size() == 0) ? 8'h00 : expQ[0];
    chk(req, rdData, e);
    if (expQ.size() != 0) void'(expQ.pop_front());
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic updAndRead(int s, bit isSig, logic [3:0] v, string req);
    chk(req, rdData, expQ[0]);
    void'(expQ.pop_front());
    rdEn     = 1'b1;
    updValid = 1'b1;
    updSlot  = 6'(s);
    updIsSig = isSig;
    updValue = v;
    modelUpd(s, isSig, v);
    @(negedge clk);
    rdEn     = 1'b0;
    updValid = 1'b0;
  endtask

  task automatic drain(string req);
    while (expQ.size() != 0) readChk(req);
    readChk(req);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      ciM[i] = '0; sigM[i] = '0; candV[i] = '0; candS[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdData", rdData, 8'h00);
    chk("R1 ovfStat", {7'b0, ovfStat}, 8'h00);

    // R2, R11: C/I change visible the next cycle
    upd(5, 1'b0, 4'd3);
    chk("R11 visible", rdData, 8'h8A);
    readChk("R2 even address");

    // R3: repeat of the same C/I value; R6 empty read
    upd(5, 1'b0, 4'd3);
    readChk("R3 no push / R6 empty");
    readChk("R6 empty read again");

    // R4: SIG needs two consecutive equal updates
    upd(7, 1'b1, 4'd2);
    chk("R4 first sight", rdData, 8'h00);
    upd(7, 1'b1, 4'd2);
    chk("R4 stable", rdData, 8'h8F);
    readChk("R4 odd address");

    // R5: glitches and restarts
    upd(7, 1'b1, 4'd5);
    upd(7, 1'b1, 4'd2);
    chk("R5 glitch back", rdData, 8'h00);
    upd(7, 1'b1, 4'd6);
    upd(7, 1'b1, 4'd1);
    chk("R5 restart", rdData, 8'h00);
    upd(7, 1'b1, 4'd1);
    readChk("R5 after restart");
    readChk("R5 empty");

    // R7: ordering across types and slots
    upd(63, 1'b0, 4'd9);
    upd(63, 1'b1, 4'd4);
    upd(0, 1'b0, 4'd1);
    upd(63, 1'b1, 4'd4);
    upd(12, 1'b0, 4'd15);
    drain("R7 order");

    // R8, R9: overflow, shadow still updated, sticky flag
    for (int s = 20; s < 29; s++) upd(s, 1'b0, 4'd7);
    chk("R8 no flag at 9", {7'b0, ovfStat}, 8'h00);
    upd(29, 1'b0, 4'd7);
    chk("R8 flag on drop", {7'b0, ovfStat}, {7'b0, expOvf});
    upd(29, 1'b0, 4'd7);
    repeat (3) @(negedge clk);
    chk("R9 sticky", {7'b0, ovfStat}, 8'h01);
    ovfRd = 1'b1;
    @(negedge clk);
    ovfRd = 1'b0;
    expOvf = 1'b0;
    chk("R9 cleared", {7'b0, ovfStat}, 8'h00);
    drain("R8 contents");

    // R10: simultaneous push and pop on a full queue
    for (int s = 30; s < 39; s++) upd(s, 1'b1, 4'd3);
    for (int s = 30; s < 39; s++) upd(s, 1'b1, 4'd3);
    updAndRead(40, 1'b0, 4'd2, "R10 swap head");
    chk("R10 no flag", {7'b0, ovfStat}, 8'h00);
    drain("R10 contents");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule